// File: doc/BRIEF.md
# LDPC Variable-Node Message Accumulator

This block is the variable-node side of an iterative LDPC decoder. One pipeline is shared in time across 2^(7+FOLD) nodes. Each node keeps three things: its channel LLR, a running total of the check-to-variable messages it has received, and a one-bit iteration tag. These live in an external simple dual-port RAM that the block drives. One port loads and unloads channel LLRs. A second port takes address-tagged messages, adds each into the total of its node, and reports the node's current belief. The belief is the channel LLR plus the total, clamped to the message range.

The block never sweeps the node memory to clear the totals between iterations. Instead, each accumulated message writes the current iteration bit into the node's tag. A later message that finds a stale tag treats the stored total as zero. The RAM writes two cycles after a request, so a later request to the same node can find its value still in flight. The block forwards these in-flight words, so any spacing of requests to one node gives the right result, including consecutive cycles.

Top module: `vnode_accum`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ram_we` is 0. After reset both `load_dout` and `msg_out` read 0.
- R2: All LLR and message values are sign-magnitude. The top bit is the sign (1 = negative) and the lower LLR_W-1 bits are the magnitude. A magnitude of 0 means zero whatever its sign. A zero result is always output with the sign bit clear.
- R3: A load write (`load_en`=1, `load_we`=1) stores the signed LLR for `load_addr` and sets that node's total to zero. A load read (`load_en`=1, `load_we`=0) returns the clamped sum of LLR and total on `load_dout`.
- R4: When `load_en`=0, `msg_we`=1 and `msg_skip`=0, the message is accumulated: its magnitude is added if the sign is 0 and subtracted if the sign is 1. When `msg_skip`=1, the node's total and tag are left unchanged and nothing is written. With `rd_req`=1, `msg_out` reports the node's clamped belief after this request's own update.
- R5: An accumulated message whose `iter_bit` differs from the node's stored tag starts from a total of zero. The tag then takes the value of `iter_bit`.
- R6: The message total saturates symmetrically at +/-(2^(LLR_W+3)-1), which is +/-127 by default.
- R7: Both outputs clamp the LLR-plus-total value to +/-(2^(LLR_W-1)-1), which is +/-7 by default.
- R8: A read result appears on its output 6 clock edges after the edge that samples the request. Each output holds its value until its next read result arrives.
- R9: Requests to the same node give correct results at every spacing, including consecutive cycles.
- R10: Each RAM word is {tag, LLR in two's complement (LLR_W bits), total in two's complement (LLR_W+4 bits)}, with the tag in the top bit. A load write or an accumulated message writes that word to the request's address two edges after the request. No other request writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Selects the LLR load port for this cycle; the message port is ignored |
| load_we | input | 1 | Load write (1) or load read (0) |
| load_addr | input | 7+FOLD | Node for the load port |
| load_din | input | LLR_W | Channel LLR to store, sign-magnitude |
| load_dout | output | LLR_W | Belief returned by a load read |
| iter_bit | input | 1 | Parity of the current decoder iteration |
| msg_we | input | 1 | Accumulate `msg_in` into the node |
| msg_skip | input | 1 | Suppress accumulation of this message |
| rd_req | input | 1 | Report the node's belief on `msg_out` |
| msg_addr | input | 7+FOLD | Node for the message port |
| msg_in | input | LLR_W | Incoming message, sign-magnitude |
| msg_out | output | LLR_W | Outgoing variable-to-check message |
| ram_rd_addr | output | 7+FOLD | RAM read address (registered-read RAM) |
| ram_wr_addr | output | 7+FOLD | RAM write address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 2*LLR_W+5 | RAM write word |
| ram_rdata | input | 2*LLR_W+5 | RAM read word, one cycle after the address |

## Verification
A wrong stored word, whether a missed tag compare, a lost forward or an unsaturated total, does not show at once. It shows on the next read of that node, six edges after that read is issued, as a belief that is off by the error. Saturation faults are hidden by the output clamp. For that reason the bench drives a total past its limit and then back by a known amount, so that a later read exposes the excess. Forwarding faults show within one to three cycles, when same-node requests come back to back or with short gaps and each request reports its own result.

// File: rtl/vnode_pkg.sv
package vnode_pkg;
   typedef enum logic [2:0] {
      OP_IDLE,
      OP_LOAD_WR,
      OP_LOAD_RD,
      OP_ACC,
      OP_PEEK
   } vn_op_e;
endpackage

// File: rtl/vnode_fwd.sv
module vnode_fwd #(
   parameter int A_W    = 8,
   parameter int WORD_W = 13
) (
   input  logic [A_W-1:0]    addr,
   input  logic [WORD_W-1:0] ram_word,
   input  logic              s2_v,
   input  logic [A_W-1:0]    s2_addr,
   input  logic [WORD_W-1:0] s2_word,
   input  logic              s3_v,
   input  logic [A_W-1:0]    s3_addr,
   input  logic [WORD_W-1:0] s3_word,
   output logic [WORD_W-1:0] word
);
   always_comb begin
      if (s2_v && s2_addr == addr)
         word = s2_word;
      else if (s3_v && s3_addr == addr)
         word = s3_word;
      else
         word = ram_word;
   end
endmodule

// File: rtl/vnode_update.sv
module vnode_update import vnode_pkg::*; #(
   parameter int LLR_W = 4
) (
   input  vn_op_e                 op,
   input  logic                   iter,
   input  logic [LLR_W-1:0]       din,
   input  logic [2*LLR_W+4:0]     cur,
   output logic [2*LLR_W+4:0]     nxt,
   output logic                   wr
);
   localparam int SUM_W  = LLR_W + 4;
   localparam int WORD_W = 2*LLR_W + 5;
   localparam logic signed [SUM_W:0] SAT_HI = (SUM_W+1)'((2**(SUM_W-1)) - 1);
   localparam logic signed [SUM_W:0] SAT_LO = -SAT_HI;

   logic                    cur_tag;
   logic [LLR_W-1:0]        cur_llr;
   logic signed [SUM_W-1:0] cur_sum;
   logic signed [LLR_W-1:0] din_val;
   logic signed [SUM_W:0]   base, acc, acc_c;

   assign cur_tag = cur[WORD_W-1];
   assign cur_llr = cur[WORD_W-2 -: LLR_W];
   assign cur_sum = cur[SUM_W-1:0];

   always_comb begin
      if (din[LLR_W-1])
         din_val = -$signed({1'b0, din[LLR_W-2:0]});
      else
         din_val = $signed({1'b0, din[LLR_W-2:0]});
   end

   always_comb begin
      base  = (cur_tag == iter) ? {cur_sum[SUM_W-1], cur_sum} : '0;
      acc   = base + {{(SUM_W+1-LLR_W){din_val[LLR_W-1]}}, din_val};
      acc_c = acc;
      if (acc > SAT_HI) acc_c = SAT_HI;
      if (acc < SAT_LO) acc_c = SAT_LO;
   end

   always_comb begin
      nxt = cur;
      wr  = 1'b0;
      case (op)
         OP_LOAD_WR: begin
            nxt = {iter, din_val, {SUM_W{1'b0}}};
            wr  = 1'b1;
         end
         OP_ACC: begin
            nxt = {iter, cur_llr, acc_c[SUM_W-1:0]};
            wr  = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/vnode_belief.sv
module vnode_belief #(
   parameter int LLR_W = 4
) (
   input  logic [2*LLR_W+4:0] word,
   output logic [LLR_W-1:0]   sm
);
   localparam int SUM_W  = LLR_W + 4;
   localparam int WORD_W = 2*LLR_W + 5;
   localparam logic signed [SUM_W:0] OMAX = (SUM_W+1)'((2**(LLR_W-1)) - 1);
   localparam logic signed [SUM_W:0] OMIN = -OMAX;

   logic [LLR_W-1:0]      llr;
   logic [SUM_W-1:0]      sum;
   logic signed [SUM_W:0] tot, tc, tneg;

   assign llr = word[WORD_W-2 -: LLR_W];
   assign sum = word[SUM_W-1:0];

   always_comb begin
      tot = $signed({{(SUM_W+1-LLR_W){llr[LLR_W-1]}}, llr}) +
            $signed({sum[SUM_W-1], sum});
      tc  = tot;
      if (tot > OMAX) tc = OMAX;
      if (tot < OMIN) tc = OMIN;
      tneg = -tc;
      if (tc < 0)
         sm = {1'b1, tneg[LLR_W-2:0]};
      else
         sm = {1'b0, tc[LLR_W-2:0]};
   end
endmodule

// File: rtl/vnode_pipe.sv
module vnode_pipe #(
   parameter int WIDTH = 6,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (DEPTH == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [DEPTH];
         for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst)
                  stg[i] <= '0;
               else if (i == 0)
                  stg[i] <= d;
               else
                  stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
         end
         assign q = stg[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/vnode_accum.sv
module vnode_accum import vnode_pkg::*; #(
   parameter int FOLD    = 1,
   parameter int LLR_W   = 4,
   parameter int OUT_LAT = 6
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load_en,
   input  logic                   load_we,
   input  logic [7+FOLD-1:0]      load_addr,
   input  logic [LLR_W-1:0]       load_din,
   output logic [LLR_W-1:0]       load_dout,
   input  logic                   iter_bit,
   input  logic                   msg_we,
   input  logic                   msg_skip,
   input  logic                   rd_req,
   input  logic [7+FOLD-1:0]      msg_addr,
   input  logic [LLR_W-1:0]       msg_in,
   output logic [LLR_W-1:0]       msg_out,
   output logic [7+FOLD-1:0]      ram_rd_addr,
   output logic [7+FOLD-1:0]      ram_wr_addr,
   output logic                   ram_we,
   output logic [2*LLR_W+4:0]     ram_wdata,
   input  logic [2*LLR_W+4:0]     ram_rdata
);
   localparam int A_W    = 7 + FOLD;
   localparam int WORD_W = 2*LLR_W + 5;
   localparam int CHAIN  = OUT_LAT - 2;
   localparam int PAY_W  = LLR_W + 2;

   generate
      if (LLR_W < 2) begin : g_bad_width
         $error("vnode_accum: LLR_W must be at least 2");
      end
      if (OUT_LAT < 2) begin : g_bad_lat
         $error("vnode_accum: OUT_LAT must be at least 2");
      end
      if (FOLD < 0) begin : g_bad_fold
         $error("vnode_accum: FOLD must not be negative");
      end
   endgenerate

   vn_op_e            req_op;
   logic [A_W-1:0]    req_addr;
   logic [LLR_W-1:0]  req_din;

   always_comb begin
      req_addr = load_en ? load_addr : msg_addr;
      req_din  = load_en ? load_din  : msg_in;
      if (load_en)
         req_op = load_we ? OP_LOAD_WR : OP_LOAD_RD;
      else if (msg_we && !msg_skip)
         req_op = OP_ACC;
      else if (rd_req)
         req_op = OP_PEEK;
      else
         req_op = OP_IDLE;
   end

   assign ram_rd_addr = req_addr;

   // stage 1: request registered, RAM word arrives
   vn_op_e            s1_op;
   logic [A_W-1:0]    s1_addr;
   logic [LLR_W-1:0]  s1_din;
   logic              s1_iter, s1_to_ld, s1_to_msg;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_op     <= OP_IDLE;
         s1_to_ld  <= 1'b0;
         s1_to_msg <= 1'b0;
      end else begin
         s1_op     <= req_op;
         s1_to_ld  <= load_en && !load_we;
         s1_to_msg <= !load_en && rd_req;
      end
      s1_addr <= req_addr;
      s1_din  <= req_din;
      s1_iter <= iter_bit;
   end

   // stages 2 and 3: write stage and just-written stage, both forwarded
   logic              s2_v, s3_v, s2_to_ld, s2_to_msg;
   logic [A_W-1:0]    s2_addr, s3_addr;
   logic [WORD_W-1:0] s2_word, s3_word, cur_word, nxt_word;
   logic              nxt_wr;

   vnode_fwd #(.A_W(A_W), .WORD_W(WORD_W)) fwd_i (
      .addr(s1_addr), .ram_word(ram_rdata),
      .s2_v(s2_v), .s2_addr(s2_addr), .s2_word(s2_word),
      .s3_v(s3_v), .s3_addr(s3_addr), .s3_word(s3_word),
      .word(cur_word)
   );

   vnode_update #(.LLR_W(LLR_W)) upd_i (
      .op(s1_op), .iter(s1_iter), .din(s1_din),
      .cur(cur_word), .nxt(nxt_word), .wr(nxt_wr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_v      <= 1'b0;
         s3_v      <= 1'b0;
         s2_to_ld  <= 1'b0;
         s2_to_msg <= 1'b0;
      end else begin
         s2_v      <= nxt_wr;
         s3_v      <= s2_v;
         s2_to_ld  <= s1_to_ld;
         s2_to_msg <= s1_to_msg;
      end
      s2_addr <= s1_addr;
      s2_word <= nxt_word;
      s3_addr <= s2_addr;
      s3_word <= s2_word;
   end

   assign ram_we      = s2_v;
   assign ram_wr_addr = s2_addr;
   assign ram_wdata   = s2_word;

   // belief, delay chain and held outputs
   logic [LLR_W-1:0] belief;
   logic [PAY_W-1:0] tail;

   vnode_belief #(.LLR_W(LLR_W)) bel_i (.word(s2_word), .sm(belief));

   vnode_pipe #(.WIDTH(PAY_W), .DEPTH(CHAIN)) pipe_i (
      .clk(clk), .rst(rst),
      .d({s2_to_ld, s2_to_msg, belief}),
      .q(tail)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         load_dout <= '0;
         msg_out   <= '0;
      end else begin
         if (tail[PAY_W-1]) load_dout <= tail[LLR_W-1:0];
         if (tail[PAY_W-2]) msg_out   <= tail[LLR_W-1:0];
      end
   end
endmodule

// File: rtl/vnode_accum_chk.sv
module vnode_accum_chk #(
   parameter int FOLD  = 1,
   parameter int LLR_W = 4
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   load_en,
   input logic                   load_we,
   input logic [7+FOLD-1:0]      load_addr,
   input logic [7+FOLD-1:0]      msg_addr,
   input logic                   msg_skip,
   input logic [LLR_W-1:0]       load_dout,
   input logic [LLR_W-1:0]       msg_out,
   input logic                   ram_we,
   input logic [7+FOLD-1:0]      ram_wr_addr,
   input logic [2*LLR_W+4:0]     ram_wdata
);
   localparam int SUM_W = LLR_W + 4;
   localparam logic [LLR_W-1:0] NEG_ZERO = {1'b1, {(LLR_W-1){1'b0}}};
   localparam logic [SUM_W-1:0] SUM_MIN  = {1'b1, {(SUM_W-1){1'b0}}};

   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !ram_we);

   a_r2_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
      (load_dout != NEG_ZERO) && (msg_out != NEG_ZERO));

   a_r3_load_clears_sum: assert property (@(posedge clk) disable iff (rst)
      (ram_we && $past(load_en && load_we, 2)) |-> ram_wdata[SUM_W-1:0] == '0);

   a_r4_skip_no_write: assert property (@(posedge clk) disable iff (rst)
      $past(!load_en && msg_skip, 2) |-> !ram_we);

   a_r6_sum_bound: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> ram_wdata[SUM_W-1:0] != SUM_MIN);

   a_r10_wr_addr: assert property (@(posedge clk) disable iff (rst)
      ram_we |-> ram_wr_addr == $past(load_en ? load_addr : msg_addr, 2));

   a_r10_read_no_write: assert property (@(posedge clk) disable iff (rst)
      $past(load_en && !load_we, 2) |-> !ram_we);
endmodule

bind vnode_accum vnode_accum_chk #(.FOLD(FOLD), .LLR_W(LLR_W)) chk_i (
   .clk(clk), .rst(rst), .load_en(load_en), .load_we(load_we),
   .load_addr(load_addr), .msg_addr(msg_addr), .msg_skip(msg_skip),
   .load_dout(load_dout), .msg_out(msg_out), .ram_we(ram_we),
   .ram_wr_addr(ram_wr_addr), .ram_wdata(ram_wdata)
);

// File: tb/vnode_accum_tb_top.sv
module vnode_accum_tb_top;
   localparam int FOLD   = 1;
   localparam int W      = 4;
   localparam int A_W    = 7 + FOLD;
   localparam int NODES  = 2**A_W;
   localparam int WORD_W = 2*W + 5;
   localparam int SAT    = 2**(W+3) - 1;
   localparam int OMAX   = 2**(W-1) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic              load_en = 0, load_we = 0, iter_bit = 0;
   logic              msg_we = 0, msg_skip = 0, rd_req = 0;
   logic [A_W-1:0]    load_addr = '0, msg_addr = '0;
   logic [W-1:0]      load_din = '0, msg_in = '0;
   logic [W-1:0]      load_dout, msg_out;
   logic [A_W-1:0]    ram_rd_addr, ram_wr_addr;
   logic              ram_we;
   logic [WORD_W-1:0] ram_wdata, ram_rdata;

   vnode_accum #(.FOLD(FOLD), .LLR_W(W)) dut_i (
      .clk(clk), .rst(rst), .load_en(load_en), .load_we(load_we),
      .load_addr(load_addr), .load_din(load_din), .load_dout(load_dout),
      .iter_bit(iter_bit), .msg_we(msg_we), .msg_skip(msg_skip),
      .rd_req(rd_req), .msg_addr(msg_addr), .msg_in(msg_in),
      .msg_out(msg_out), .ram_rd_addr(ram_rd_addr), .ram_wr_addr(ram_wr_addr),
      .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   // behavioural RAM: registered read, old data on a same-edge collision
   logic [WORD_W-1:0] mem [NODES];
   initial for (int i = 0; i < NODES; i++) mem[i] = '0;
   always @(posedge clk) begin
      if (ram_we) mem[ram_wr_addr] <= ram_wdata;
      ram_rdata <= mem[ram_rd_addr];
   end

   int errors = 0;
   int checks = 0;

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_word(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int dec(input logic [W-1:0] v);
      int m = int'(v[W-2:0]);
      return v[W-1] ? -m : m;
   endfunction

   function automatic logic [W-1:0] enc(input int v);
      int c = v;
      if (c > OMAX) c = OMAX;
      if (c < -OMAX) c = -OMAX;
      if (c < 0) return {1'b1, (W-1)'(-c)};
      return {1'b0, (W-1)'(c)};
   endfunction

   // reference model state
   int  m_llr [NODES];
   int  m_sum [NODES];
   bit  m_tag [NODES];
   bit  iter = 0;

   // expected-result slots: issued at negedge k, visible at negedge k+7
   int          sl_kind [8];
   logic [W-1:0] sl_val [8];
   string       sl_tag  [8];
   logic [W-1:0] hold_ld = '0, hold_msg = '0;
   int          kcount = 0;

   // op: 0 idle, 1 load write, 2 load read, 3 message, 4 message read only
   task automatic cyc_op(input int op, input int addr, input logic [W-1:0] data,
                         input bit skip, input bit rd, input string tag);
      int s, w, base, acc;
      @(negedge clk);
      s = (kcount + 1) % 8;
      if (sl_kind[s] == 1) hold_ld  = sl_val[s];
      if (sl_kind[s] == 2) hold_msg = sl_val[s];
      chk((sl_kind[s] == 1) ? sl_tag[s] : "R8", load_dout, hold_ld);
      chk((sl_kind[s] == 2) ? sl_tag[s] : "R8", msg_out, hold_msg);
      w = kcount % 8;
      sl_kind[w] = 0;
      sl_tag[w]  = tag;
      load_en   = (op == 1 || op == 2);
      load_we   = (op == 1);
      load_addr = A_W'(addr);
      load_din  = data;
      msg_we    = (op == 3);
      msg_skip  = skip;
      rd_req    = rd || op == 4;
      msg_addr  = A_W'(addr);
      msg_in    = data;
      iter_bit  = iter;
      case (op)
         1: begin m_llr[addr] = dec(data); m_sum[addr] = 0; m_tag[addr] = iter; end
         2: begin sl_kind[w] = 1; sl_val[w] = enc(m_llr[addr] + m_sum[addr]); end
         3: begin
            if (!skip) begin
               base = (m_tag[addr] != iter) ? 0 : m_sum[addr];
               acc  = base + dec(data);
               if (acc > SAT)  acc = SAT;
               if (acc < -SAT) acc = -SAT;
               m_sum[addr] = acc;
               m_tag[addr] = iter;
            end
            if (rd) begin sl_kind[w] = 2; sl_val[w] = enc(m_llr[addr] + m_sum[addr]); end
         end
         4: begin sl_kind[w] = 2; sl_val[w] = enc(m_llr[addr] + m_sum[addr]); end
         default: ;
      endcase
      kcount++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc_op(0, 0, '0, 0, 0, "R8");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R8: watchdog expired, got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin sl_kind[i] = 0; sl_val[i] = '0; sl_tag[i] = "R8"; end
      for (int i = 0; i < NODES; i++) begin m_llr[i] = 0; m_sum[i] = 0; m_tag[i] = 0; end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", load_dout, '0);
      chk("R1", msg_out, '0);
      checks++;
      if (ram_we !== 1'b0) begin errors++; $display("FAIL R1: got ram_we=%b expected 0", ram_we); end

      // R3/R2: load every node, magnitudes 0..7 with both signs
      for (int i = 0; i < NODES; i++)
         cyc_op(1, i, {1'((i/8)%2), 3'(i%8)}, 0, 0, "R3");
      for (int i = 0; i < NODES; i++)
         cyc_op(2, i, '0, 0, 0, (i%8 == 0) ? "R2" : "R3");
      // R10: RAM word layout for +5 and -5 (sum zero, tag 0)
      chk_word("R10", mem[5],  {1'b0, 4'b0101, 8'h00});
      chk_word("R10", mem[13], {1'b0, 4'b1011, 8'h00});

      // R4: accumulate with some messages skipped, then read back
      for (int i = 0; i < 64; i++)
         cyc_op(3, i, {1'(i%2), 3'((i*3)%8)}, (i%5 == 0), 0, "R4");
      for (int i = 0; i < 64; i++) cyc_op(4, i, '0, 0, 0, "R4");
      for (int i = 0; i < 8; i++)  cyc_op(2, i, '0, 0, 0, "R3");

      // R9: same node back to back and with gaps of 1..4 cycles
      cyc_op(1, 100, 4'b0000, 0, 0, "R9");
      cyc_op(1, 101, 4'b0001, 0, 0, "R9");
      for (int k = 0; k < 6; k++)
         cyc_op(3, 100, {1'(k%2), 3'((k%3)+1)}, 0, 1, "R9");
      for (int k = 0; k < 6; k++)
         cyc_op(3, 100 + (k%2), {1'((k/2)%2), 3'(k+1)}, 0, 1, "R9");
      for (int g = 1; g <= 4; g++) begin
         idle(g);
         cyc_op(3, 100, {1'(g%2), 3'(g+2)}, 0, 1, "R9");
      end

      // R6: drive total to +127, back by 126, then to -127, back by 126
      cyc_op(1, 120, 4'b0000, 0, 0, "R6");
      for (int k = 0; k < 25; k++) cyc_op(3, 120, 4'b0111, 0, 0, "R6");
      for (int k = 0; k < 18; k++) cyc_op(3, 120, 4'b1111, 0, 0, "R6");
      cyc_op(4, 120, '0, 0, 0, "R6");
      for (int k = 0; k < 40; k++) cyc_op(3, 120, 4'b1111, 0, 0, "R6");
      for (int k = 0; k < 18; k++) cyc_op(3, 120, 4'b0111, 0, 0, "R6");
      cyc_op(4, 120, '0, 0, 0, "R6");

      // R7: output clamps at both ends
      cyc_op(1, 130, 4'b0111, 0, 0, "R7");
      cyc_op(1, 131, 4'b1111, 0, 0, "R7");
      cyc_op(3, 130, 4'b0101, 0, 1, "R7");
      cyc_op(3, 131, 4'b1101, 0, 1, "R7");
      cyc_op(2, 130, '0, 0, 0, "R7");
      cyc_op(2, 131, '0, 0, 0, "R7");

      // R5: new iteration parity restarts totals lazily
      iter = 1;
      for (int i = 0; i < 16; i++) cyc_op(3, i, 4'b0001, 0, 1, "R5");
      for (int i = 0; i < 16; i++) cyc_op(3, i, 4'b0001, 0, 1, "R5");
      cyc_op(3, 20, 4'b0011, 1, 1, "R4");
      cyc_op(4, 20, '0, 0, 0, "R4");
      iter = 0;
      for (int i = 0; i < 4; i++) cyc_op(3, i, 4'b1010, 0, 1, "R5");
      cyc_op(3, 20, 4'b0001, 0, 1, "R5");

      idle(10);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule